// File: doc/BRIEF.md
# Selectable Arithmetic Microoperation Unit

This block performs one of eight arithmetic microoperations on an N-bit operand pair using a single adder. The adder always computes `A + Y + carry-in`; the operation is chosen only by what is placed on the Y input and by the carry-in bit. A two-bit operand select picks Y from four sources: B, the bitwise inverse of B, all zeros or all ones. The carry-in is a separate input. It is not part of the select. Together these give add, add plus one, subtract with borrow, true subtract, transfer, increment and decrement.

The result and the adder's carry-out are captured into output registers on a cycle in which the load strobe is high. Otherwise both registers keep their value. A controller drives A, B, the select, the carry-in and the load strobe in one cycle. It reads the registered result from the next cycle onwards.

Top module: `arith_unit`

## Requirements
- R1: With select code 2'b00, a load captures the low N bits of A + B + cin into the result register.
- R2: With select code 2'b01, a load captures A + ~B + cin modulo 2^N. cin=1 gives A - B and cin=0 gives A - B - 1.
- R3: With select code 2'b10, a load captures A + cin. cin=0 transfers A and cin=1 increments it.
- R4: With select code 2'b11, a load captures A + (2^N - 1) + cin. cin=0 gives A - 1 and cin=1 transfers A.
- R5: The carry output is bit N of the (N+1)-bit sum A + Y + cin. It is captured on the same clock edge as the result.
- R6: While load is low, the result and the carry output keep their values whatever the other inputs do.
- R7: An active-low asynchronous reset clears the result and the carry output to zero.
- R8: All results wrap modulo 2^N. For example, with N=8, 8'hFF plus one gives 8'h00 with carry 1, and 8'h00 minus one gives 8'hFF with carry 0.
- R9: A load on one rising edge makes its result and carry visible from that edge until the next load or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | N | Operand A |
| b_i | input | N | Operand B |
| sel_i | input | 2 | Y source: 00 B, 01 ~B, 10 zeros, 11 ones |
| cin_i | input | 1 | Adder carry-in |
| load_i | input | 1 | Capture strobe for result and carry |
| d_o | output | N | Registered result |
| cout_o | output | 1 | Registered adder carry-out |

## Verification
All eight select and carry-in codes are applied to several operand pairs:
- Zero operands show whether the carry-in reaches the result.
- Equal operands separate true subtract from subtract with borrow.
- All-ones and mixed patterns expose a wrong inverse or constant on Y.
- Values near the top and bottom of the range check the carry-out and the modulo wrap.

Cycles with load low are placed between loads, and their inputs are changed, so a hold failure is visible. A final mid-run reset checks that the clear acts at once, without waiting for a clock edge.

// File: rtl/arith_pkg.sv
package arith_pkg;
  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NB   = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;
endpackage

// File: rtl/arith_operand_mux.sv
module arith_operand_mux
  import arith_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] b_i,
  input  ysel_e        sel_i,
  output logic [N-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      YSEL_B:    y_o = b_i;
      YSEL_NB:   y_o = ~b_i;
      YSEL_ZERO: y_o = '0;
      default:   y_o = '1;
    endcase
  end
endmodule

// File: rtl/arith_adder.sv
module arith_adder #(
  parameter int N      = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] y_i,
  input  logic         cin_i,
  output logic [N:0]   sum_o
);
  if (RIPPLE) begin : g_ripple
    logic [N:0]   c;
    logic [N-1:0] s;
    assign c[0] = cin_i;
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign s[i]   = a_i[i] ^ y_i[i] ^ c[i];
      assign c[i+1] = (a_i[i] & y_i[i]) | (c[i] & (a_i[i] ^ y_i[i]));
    end
    assign sum_o = {c[N], s};
  end else begin : g_native
    assign sum_o = {1'b0, a_i} + {1'b0, y_i} + {{N{1'b0}}, cin_i};
  end
endmodule

// File: rtl/arith_result_reg.sv
module arith_result_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N:0]   sum_i,
  output logic [N-1:0] d_o,
  output logic         cout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o    <= '0;
      cout_o <= 1'b0;
    end else if (load_i) begin
      d_o    <= sum_i[N-1:0];
      cout_o <= sum_i[N];
    end
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(d_o) && $stable(cout_o)));

  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (d_o == $past(sum_i[N-1:0]) && cout_o == $past(sum_i[N])));
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
#(
  parameter int N      = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [1:0]   sel_i,
  input  logic         cin_i,
  input  logic         load_i,
  output logic [N-1:0] d_o,
  output logic         cout_o
);
  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

  ysel_e        sel;
  logic [N-1:0] y;
  logic [N:0]   sum;

  assign sel = ysel_e'(sel_i);

  arith_operand_mux #(.N(N)) u_mux (
    .b_i   (b_i),
    .sel_i (sel),
    .y_o   (y)
  );

  arith_adder #(.N(N), .RIPPLE(RIPPLE)) u_add (
    .a_i   (a_i),
    .y_i   (y),
    .cin_i (cin_i),
    .sum_o (sum)
  );

  arith_result_reg #(.N(N)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .sum_i  (sum),
    .d_o    (d_o),
    .cout_o (cout_o)
  );

  a_r3_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b10 && !cin_i) |-> (sum == {1'b0, a_i}));

  a_r4_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b11 && cin_i) |-> (sum == {1'b1, a_i}));

  a_r2_self_diff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b01 && cin_i && a_i == b_i) |-> (sum == {1'b1, {N{1'b0}}}));

  a_r1_add_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b00 && b_i == '0 && !cin_i) |-> (sum == {1'b0, a_i}));

  a_r8_wrap_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b11 && !cin_i && a_i == '0) |-> (sum == {1'b0, ALL_ONES}));

  a_r7_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (d_o == '0 && !cout_o));
endmodule

// File: tb/sim_arith_unit.sv
module sim_arith_unit;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic [1:0]   sel = '0;
  logic         cin = 1'b0, load = 1'b0;
  logic [N-1:0] d;
  logic         cout;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [N-1:0] exp_d_q[$];
  logic         exp_c_q[$];
  string        exp_tag_q[$];
  logic [N-1:0] model_d = '0;
  logic         model_c = 1'b0;

  always #10 clk = ~clk;

  arith_unit #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .sel_i(sel),
    .cin_i(cin), .load_i(load), .d_o(d), .cout_o(cout)
  );

  function automatic string tag_for(logic [1:0] s);
    case (s)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] ad, logic ac, logic [N-1:0] ed, logic ec);
    checks++;
    if (ad !== ed || ac !== ec) begin
      errors++;
      $display("FAIL %s: d=%h cout=%b expected d=%h cout=%b", tag, ad, ac, ed, ec);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected registered state
  task automatic step(logic ld, logic [N-1:0] av, logic [N-1:0] bv,
                      logic [1:0] s, logic c, string tag);
    logic [N-1:0] y;
    logic [N:0]   sum;
    @(negedge clk);
    a = av; b = bv; sel = s; cin = c; load = ld;
    case (s)
      2'b00: y = bv;
      2'b01: y = ~bv;
      2'b10: y = '0;
      default: y = '1;
    endcase
    sum = {1'b0, av} + {1'b0, y} + {{N{1'b0}}, c};
    if (ld) begin
      model_d = sum[N-1:0];
      model_c = sum[N];
    end
    exp_d_q.push_back(model_d);
    exp_c_q.push_back(model_c);
    exp_tag_q.push_back(tag);
  endtask

  // monitor: pops one item per edge, compares away from the edge (R9)
  initial begin
    forever begin
      @(posedge clk);
      if (exp_d_q.size() > 0) begin
        logic [N-1:0] ed;
        logic ec;
        string t;
        ed = exp_d_q.pop_front();
        ec = exp_c_q.pop_front();
        t  = exp_tag_q.pop_front();
        @(negedge clk);
        check(t, d, cout, ed, ec);
      end
    end
  end

  initial begin
    logic [N-1:0] va[6];
    logic [N-1:0] vb[6];
    va = '{8'h00, 8'h37, 8'hFF, 8'h80, 8'h5A, 8'h01};
    vb = '{8'h00, 8'h37, 8'hFF, 8'h7F, 8'hA5, 8'h02};

    #1;
    check("R7", d, cout, '0, 1'b0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 6; k++) begin
          step(1'b1, va[k], vb[k], 2'(s), 1'(c), tag_for(2'(s)));
        end
        step(1'b0, 8'hC3, 8'h3C, 2'(3 - s), 1'(1 - c), "R6");
        step(1'b0, 8'h11, 8'hEE, 2'(s), 1'(c), "R6");
      end
    end

    step(1'b1, 8'hFF, 8'h00, 2'b10, 1'b1, "R8");
    step(1'b1, 8'h00, 8'h00, 2'b11, 1'b0, "R8");
    step(1'b1, 8'hFF, 8'h01, 2'b00, 1'b0, "R8");
    step(1'b1, 8'hF0, 8'h20, 2'b00, 1'b1, "R5");
    step(1'b1, 8'h10, 8'h20, 2'b01, 1'b1, "R5");
    step(1'b1, 8'h20, 8'h10, 2'b01, 1'b1, "R5");
    step(1'b0, 8'hFF, 8'hFF, 2'b00, 1'b1, "R6");
    step(1'b1, 8'h7E, 8'h00, 2'b10, 1'b1, "R9");
    step(1'b0, 8'h00, 8'h00, 2'b00, 1'b0, "R9");

    while (exp_d_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #3 rst_ni = 1'b0;
    #2;
    check("R7", d, cout, '0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7", d, cout, '0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule